// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on the outbound path of a link controller. It turns a memory-side request address into a link-side address and an action word. The action word tells a downstream packet builder what kind of transaction to emit: its type, its traffic class and its ordering flags. A bank of programmable windows does the translation. Each window holds a 64-bit match value, a 64-bit remap value, a 64-bit mask and a 32-bit action word. The enable bit of a window is bit 0 of its match value. A request hits a window when the window is enabled and the request address agrees with the match value in every bit where the mask is 1. The block then replaces the masked bits of the address with the corresponding remap bits.

When no window hits, a global pin selects what happens. If default mapping is enabled, the address passes through untouched and carries a separate default action word. If default mapping is disabled, the request completes with an error flag instead of a translation. All window and default registers sit behind a plain write/read register port. Lookups flow through a valid/ready pipeline with one registered stage.

The stage is a two-state machine. `ST_EMPTY` means that no result is held. The transition *accept* (request valid while ready) moves it to `ST_HOLD`. In `ST_HOLD` a result is presented. *Drain-and-refill* (consumer ready and a new request accepted) stays in `ST_HOLD`. *Drain* (consumer ready, no new request) returns to `ST_EMPTY`. *Stall* (consumer not ready) stays in `ST_HOLD` with the result frozen.

Top module: `owt_xlat`

## Requirements
- R1: After reset, rsp_valid is 0, req_ready is 1 and every register location reads 0, so every window is disabled and the default action is 0.
- R2: Window w occupies register byte offsets w*0x20 to w*0x20+0x1C, and bits 1:0 of the register address are ignored. Within a window, the match value low and high words sit at +0x0 and +0x4, remap low and high at +0x8 and +0xC, mask low and high at +0x10 and +0x14, and the action word at +0x18. The default action word sits at +0x1C of the last window (offset 0xFC with 8 windows). Every location reads back what was last written to it. The +0x1C slot of any other window, and any unmapped offset, reads 0 and ignores writes.
- R3: Mask bits 15:0 always read as 0 and never take part in matching or translation, so translated address bits 15:0 always equal request address bits 15:0.
- R4: A window can hit only while bit 0 of its match value is 1. Writing all of its registers to 0 disables it.
- R5: On a hit, rsp_addr = (req_addr AND NOT mask) OR (remap AND mask), rsp_action is that window's action word passed through bit for bit, rsp_hit = 1, rsp_err = 0 and rsp_win is the window number. In the action word, bits 3:0 are the type (memory 0x0, I/O 0x4, config type 0 0x8, config type 1 0x9, message 0xC), bits 10:8 are the traffic class, bit 11 enables the attributes, and bits 7:4 are the ordering, snoop, poison and ID-ordering flags.
- R6: When several enabled windows hit, the lowest-numbered one is used.
- R7: On a miss with dflt_map_en = 1, rsp_addr equals req_addr, rsp_action is the default action word, and rsp_hit = 0, rsp_err = 0.
- R8: On a miss with dflt_map_en = 0, rsp_err = 1, rsp_hit = 0, rsp_action = 0 and rsp_addr equals req_addr.
- R9: A request accepted at a clock edge has its result on the outputs with rsp_valid = 1 right after that edge.
- R10: req_ready = NOT rsp_valid OR rsp_ready. While rsp_valid = 1 and rsp_ready = 0, every rsp_* output holds its value.
- R11: A register write in the same cycle as an accepted lookup does not affect that lookup, which sees the old contents. A held result is not changed by later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset (log2(NUM_WIN)+5 bits) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| dflt_map_en | input | 1 | Enables pass-through with the default action on a miss |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high with req_valid |
| req_addr | input | 64 | Memory-side request address |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_action | output | 32 | Action word of the hit window, default action, or 0 on error |
| rsp_hit | output | 1 | A window hit |
| rsp_win | output | 3 | Number of the hit window (log2(NUM_WIN) bits), 0 on a miss |
| rsp_err | output | 1 | Miss with default mapping disabled |

## Verification
A register write and a lookup can land on the same clock edge, and the write may change the very window the lookup is matching against. The bench provokes this in two ways. A directed case disables a window in the same cycle as a request that hits it. Random traffic also mixes register writes with requests and consumer stalls. Each result is judged against a bench model that evaluates the lookup on the register image from before the write and applies the write afterwards. Results held during a stall must stay frozen while the windows are rewritten underneath them.

// File: rtl/owt_pkg.sv
package owt_pkg;

    localparam int ADDR_W = 64;
    localparam int REG_W  = 32;

    // transaction type codes carried in bits 3:0 of an action word
    typedef enum logic [3:0] {
        ACT_MEM  = 4'h0,
        ACT_IO   = 4'h4,
        ACT_CFG0 = 4'h8,
        ACT_CFG1 = 4'h9,
        ACT_MSG  = 4'hC
    } act_type_e;

    // register slot inside one window block (address bits 4:2)
    typedef enum logic [2:0] {
        SLOT_MATCH_LO = 3'd0,
        SLOT_MATCH_HI = 3'd1,
        SLOT_REMAP_LO = 3'd2,
        SLOT_REMAP_HI = 3'd3,
        SLOT_MASK_LO  = 3'd4,
        SLOT_MASK_HI  = 3'd5,
        SLOT_ACTION   = 3'd6,
        SLOT_SPARE    = 3'd7
    } slot_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } pipe_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  action;
        logic              hit;
        logic              err;
    } xlat_res_t;

endpackage

// File: rtl/owt_regs.sv
module owt_regs
    import owt_pkg::*;
#(
    parameter int NUM_WIN      = 8,
    parameter int MIN_WIN_LOG2 = 16,
    parameter int CFG_AW       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [ADDR_W-1:0] match_q  [NUM_WIN],
    output logic [ADDR_W-1:0] remap_q  [NUM_WIN],
    output logic [ADDR_W-1:0] mask_q   [NUM_WIN],
    output logic [REG_W-1:0]  action_q [NUM_WIN],
    output logic [REG_W-1:0]  dflt_q
);

    localparam int WIN_BITS = CFG_AW - 5;
    localparam logic [REG_W-1:0] LO_KEEP = ~((REG_W'(1) << MIN_WIN_LOG2) - REG_W'(1));

    logic [WIN_BITS-1:0] win_sel;
    slot_e               slot;
    logic                unused_lsb;

    assign win_sel    = addr[CFG_AW-1:5];
    assign slot       = slot_e'(addr[4:2]);
    assign unused_lsb = ^addr[1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                match_q[w]  <= '0;
                remap_q[w]  <= '0;
                mask_q[w]   <= '0;
                action_q[w] <= '0;
            end
            dflt_q <= '0;
        end else if (wr_en) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (win_sel == WIN_BITS'(w)) begin
                    case (slot)
                        SLOT_MATCH_LO: match_q[w][31:0]  <= wdata;
                        SLOT_MATCH_HI: match_q[w][63:32] <= wdata;
                        SLOT_REMAP_LO: remap_q[w][31:0]  <= wdata;
                        SLOT_REMAP_HI: remap_q[w][63:32] <= wdata;
                        SLOT_MASK_LO:  mask_q[w][31:0]   <= wdata & LO_KEEP;
                        SLOT_MASK_HI:  mask_q[w][63:32]  <= wdata;
                        SLOT_ACTION:   action_q[w]       <= wdata;
                        SLOT_SPARE: begin
                            if (w == NUM_WIN - 1) dflt_q <= wdata;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (win_sel == WIN_BITS'(w)) begin
                case (slot)
                    SLOT_MATCH_LO: rdata = match_q[w][31:0];
                    SLOT_MATCH_HI: rdata = match_q[w][63:32];
                    SLOT_REMAP_LO: rdata = remap_q[w][31:0];
                    SLOT_REMAP_HI: rdata = remap_q[w][63:32];
                    SLOT_MASK_LO:  rdata = mask_q[w][31:0];
                    SLOT_MASK_HI:  rdata = mask_q[w][63:32];
                    SLOT_ACTION:   rdata = action_q[w];
                    SLOT_SPARE:    rdata = (w == NUM_WIN - 1) ? dflt_q : '0;
                    default:       rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/owt_win_match.sv
module owt_win_match
    import owt_pkg::*;
#(
    parameter int MIN_WIN_LOG2 = 16
) (
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] match_val,
    input  logic [ADDR_W-1:0] remap_val,
    input  logic [ADDR_W-1:0] mask_val,
    output logic              hit,
    output logic [ADDR_W-1:0] xaddr
);

    localparam logic [ADDR_W-1:0] FLOOR = ~((ADDR_W'(1) << MIN_WIN_LOG2) - ADDR_W'(1));

    logic [ADDR_W-1:0] eff_mask;
    logic [ADDR_W-1:0] diff;

    // bits below the minimum window size never compare or remap
    assign eff_mask = mask_val & FLOOR;
    assign diff     = (req_addr ^ match_val) & eff_mask;
    assign hit      = match_val[0] && (diff == '0);
    assign xaddr    = (req_addr & ~eff_mask) | (remap_val & eff_mask);

endmodule

// File: rtl/owt_pick.sv
module owt_pick #(
    parameter int NUM_WIN  = 8,
    parameter int WIN_BITS = 3
) (
    input  logic [NUM_WIN-1:0]  hit_vec,
    output logic                any_hit,
    output logic [WIN_BITS-1:0] idx
);

    assign any_hit = |hit_vec;

    // scan from the top so the lowest set index is the last assignment
    always_comb begin
        idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) idx = WIN_BITS'(i);
        end
    end

endmodule

// File: rtl/owt_xlat.sv
module owt_xlat
    import owt_pkg::*;
#(
    parameter int   NUM_WIN      = 8,
    parameter int   MIN_WIN_LOG2 = 16,
    localparam int  WIN_BITS     = $clog2(NUM_WIN),
    localparam int  CFG_AW       = WIN_BITS + 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic [REG_W-1:0]    cfg_rdata,
    input  logic                dflt_map_en,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic [ADDR_W-1:0]   rsp_addr,
    output logic [REG_W-1:0]    rsp_action,
    output logic                rsp_hit,
    output logic [WIN_BITS-1:0] rsp_win,
    output logic                rsp_err
);

    logic [ADDR_W-1:0] match_q  [NUM_WIN];
    logic [ADDR_W-1:0] remap_q  [NUM_WIN];
    logic [ADDR_W-1:0] mask_q   [NUM_WIN];
    logic [REG_W-1:0]  action_q [NUM_WIN];
    logic [REG_W-1:0]  dflt_q;

    owt_regs #(
        .NUM_WIN      (NUM_WIN),
        .MIN_WIN_LOG2 (MIN_WIN_LOG2),
        .CFG_AW       (CFG_AW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .match_q  (match_q),
        .remap_q  (remap_q),
        .mask_q   (mask_q),
        .action_q (action_q),
        .dflt_q   (dflt_q)
    );

    logic [NUM_WIN-1:0] hit_vec;
    logic [ADDR_W-1:0]  xaddr_v [NUM_WIN];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        owt_win_match #(
            .MIN_WIN_LOG2 (MIN_WIN_LOG2)
        ) u_match (
            .req_addr  (req_addr),
            .match_val (match_q[w]),
            .remap_val (remap_q[w]),
            .mask_val  (mask_q[w]),
            .hit       (hit_vec[w]),
            .xaddr     (xaddr_v[w])
        );
    end

    logic                any_hit;
    logic [WIN_BITS-1:0] pick_idx;

    owt_pick #(
        .NUM_WIN  (NUM_WIN),
        .WIN_BITS (WIN_BITS)
    ) u_pick (
        .hit_vec (hit_vec),
        .any_hit (any_hit),
        .idx     (pick_idx)
    );

    xlat_res_t           res_d;
    logic [WIN_BITS-1:0] win_d;

    always_comb begin
        res_d      = '0;
        res_d.addr = req_addr;
        win_d      = '0;
        if (any_hit) begin
            res_d.addr   = xaddr_v[pick_idx];
            res_d.action = action_q[pick_idx];
            res_d.hit    = 1'b1;
            win_d        = pick_idx;
        end else if (dflt_map_en) begin
            res_d.action = dflt_q;
        end else begin
            res_d.err = 1'b1;
        end
    end

    // ---------------- output stage state machine ----------------
    pipe_state_e state_q, state_d;
    logic        accept;

    assign req_ready = (state_q == ST_EMPTY) || rsp_ready;
    assign accept    = req_valid && req_ready;
    assign rsp_valid = (state_q == ST_HOLD);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_HOLD;
            ST_HOLD:  if (rsp_ready && !req_valid) state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    xlat_res_t           res_q;
    logic [WIN_BITS-1:0] win_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            win_q <= '0;
        end else if (accept) begin
            res_q <= res_d;
            win_q <= win_d;
        end
    end

    assign rsp_addr   = res_q.addr;
    assign rsp_action = res_q.action;
    assign rsp_hit    = res_q.hit;
    assign rsp_err    = res_q.err;
    assign rsp_win    = win_q;

    // ---------------- assertions ----------------
    logic [NUM_WIN-1:0] below_pick;
    assign below_pick = (NUM_WIN'(1) << pick_idx) - NUM_WIN'(1);

    p_lowest_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (hit_vec[pick_idx] && ((hit_vec & below_pick) == '0)));

    p_result_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);

    p_low_bits_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (rsp_addr[MIN_WIN_LOG2-1:0] == $past(req_addr[MIN_WIN_LOG2-1:0])));

    p_default_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dflt_map_en) |=> !rsp_err);

    p_ready_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready);

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_action)
                                       && $stable(rsp_hit) && $stable(rsp_err) && $stable(rsp_win)));

    p_hit_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_hit && rsp_err));

endmodule

// File: tb/owt_xlat_tb.sv
`timescale 1ns/1ps
module owt_xlat_tb_top;
    import owt_pkg::*;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic [7:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        dflt_map_en;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_addr;
    logic        rsp_valid;
    logic        rsp_ready;
    logic [63:0] rsp_addr;
    logic [31:0] rsp_action;
    logic        rsp_hit;
    logic [2:0]  rsp_win;
    logic        rsp_err;

    always #(HALF) clk = ~clk;

    owt_xlat dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dflt_map_en(dflt_map_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .rsp_action(rsp_action), .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_err(rsp_err)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench image of the register file
    logic [63:0] m_match [8];
    logic [63:0] m_remap [8];
    logic [63:0] m_mask  [8];
    logic [31:0] m_act   [8];
    logic [31:0] m_dflt;

    // expected output register
    logic        exp_v;
    logic [63:0] exp_addr;
    logic [31:0] exp_act;
    logic        exp_hit;
    logic        exp_err;
    int          exp_win;
    string       exp_tag;

    task automatic check(input logic [63:0] got, input logic [63:0] want,
                         input string req, input string what);
        n_chk++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, want);
        end
    endtask

    function automatic logic [7:0] adr(input int w, input int s);
        return 8'(w * 32 + s * 4);
    endfunction

    task automatic model_reset();
        for (int w = 0; w < 8; w++) begin
            m_match[w] = '0; m_remap[w] = '0; m_mask[w] = '0; m_act[w] = '0;
        end
        m_dflt = '0;
        exp_v = 0; exp_addr = '0; exp_act = '0; exp_hit = 0; exp_err = 0; exp_win = 0;
        exp_tag = "R9";
    endtask

    task automatic model_write(input logic [7:0] wa, input logic [31:0] wd);
        int w;
        w = int'(wa[7:5]);
        case (wa[4:2])
            3'd0: m_match[w][31:0]  = wd;
            3'd1: m_match[w][63:32] = wd;
            3'd2: m_remap[w][31:0]  = wd;
            3'd3: m_remap[w][63:32] = wd;
            3'd4: m_mask[w][31:0]   = wd & 32'hFFFF_0000;
            3'd5: m_mask[w][63:32]  = wd;
            3'd6: m_act[w]          = wd;
            default: if (w == 7) m_dflt = wd;
        endcase
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] ra);
        int w;
        w = int'(ra[7:5]);
        case (ra[4:2])
            3'd0: return m_match[w][31:0];
            3'd1: return m_match[w][63:32];
            3'd2: return m_remap[w][31:0];
            3'd3: return m_remap[w][63:32];
            3'd4: return m_mask[w][31:0];
            3'd5: return m_mask[w][63:32];
            3'd6: return m_act[w];
            default: return (w == 7) ? m_dflt : 32'h0;
        endcase
    endfunction

    task automatic model_lookup(input logic [63:0] a, input logic den, output logic [63:0] oa,
                                output logic [31:0] oact, output logic oh, output logic oe,
                                output int ow, output int nhits);
        oa = a; oact = '0; oh = 0; oe = 0; ow = 0; nhits = 0;
        for (int w = 0; w < 8; w++) begin
            if (m_match[w][0] && (((a ^ m_match[w]) & m_mask[w]) == 64'h0)) begin
                nhits++;
                if (!oh) begin
                    oh = 1; ow = w; oact = m_act[w];
                    oa = (a & ~m_mask[w]) | (m_remap[w] & m_mask[w]);
                end
            end
        end
        if (!oh) begin
            if (den) oact = m_dflt;
            else     oe = 1;
        end
    endtask

    // one cycle: check held outputs, drive new inputs, advance the model
    task automatic step(input logic v, input logic [63:0] a, input logic den, input logic ordy,
                        input logic we, input logic [7:0] wa, input logic [31:0] wd,
                        input string tag);
        logic fire;
        int   nh;
        @(negedge clk);
        check(64'(rsp_valid), 64'(exp_v), "R9", "rsp_valid");
        if (exp_v) begin
            check(rsp_addr, exp_addr, exp_tag, "rsp_addr");
            check(64'(rsp_action), 64'(exp_act), exp_tag, "rsp_action");
            check(64'(rsp_hit), 64'(exp_hit), exp_tag, "rsp_hit");
            check(64'(rsp_err), 64'(exp_err), exp_tag, "rsp_err");
            if (exp_hit) check(64'(rsp_win), 64'(exp_win), exp_tag, "rsp_win");
        end
        req_valid = v; req_addr = a; dflt_map_en = den; rsp_ready = ordy;
        cfg_wr_en = we; cfg_addr = wa; cfg_wdata = wd;
        #1;
        check(64'(req_ready), 64'(!exp_v || ordy), "R10", "req_ready");
        fire = v && (!exp_v || ordy);
        if (fire) begin
            model_lookup(a, den, exp_addr, exp_act, exp_hit, exp_err, exp_win, nh);
            exp_v = 1;
            if (tag != "")      exp_tag = tag;
            else if (nh > 1)    exp_tag = "R6";
            else if (exp_hit)   exp_tag = "R5";
            else if (exp_err)   exp_tag = "R8";
            else                exp_tag = "R7";
        end else if (ordy) begin
            exp_v = 0;
        end
        if (we) model_write(wa, wd);
    endtask

    task automatic wr(input logic [7:0] wa, input logic [31:0] wd);
        step(0, 64'h0, 1, 1, 1, wa, wd, "");
    endtask

    task automatic rd_chk(input logic [7:0] ra, input logic [31:0] want, input string req);
        @(negedge clk);
        req_valid = 0; rsp_ready = 1; cfg_wr_en = 0; cfg_addr = ra;
        #1;
        check(64'(cfg_rdata), 64'(want), req, "cfg_rdata");
        exp_v = 0;
    endtask

    task automatic lookup(input logic [63:0] a, input logic den, input string tag);
        step(1, a, den, 1, 0, 8'h0, 32'h0, tag);
    endtask

    task automatic prog_win(input int w, input logic [63:0] mt, input logic [63:0] rm,
                            input logic [63:0] mk, input logic [31:0] ac);
        wr(adr(w, 0), mt[31:0]);  wr(adr(w, 1), mt[63:32]);
        wr(adr(w, 2), rm[31:0]);  wr(adr(w, 3), rm[63:32]);
        wr(adr(w, 4), mk[31:0]);  wr(adr(w, 5), mk[63:32]);
        wr(adr(w, 6), ac);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R9 watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        model_reset();
        rst_n = 0; cfg_wr_en = 0; cfg_addr = '0; cfg_wdata = '0; dflt_map_en = 0;
        req_valid = 0; req_addr = '0; rsp_ready = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        @(negedge clk);
        #1;
        check(64'(rsp_valid), 64'h0, "R1", "rsp_valid after reset");
        check(64'(req_ready), 64'h1, "R1", "req_ready after reset");
        rd_chk(adr(0, 0), 32'h0, "R1");
        rd_chk(adr(4, 5), 32'h0, "R1");
        rd_chk(adr(7, 7), 32'h0, "R1");

        // R2: map and readback
        for (int s = 0; s < 7; s++) wr(adr(3, s), 32'hA500_0000 | 32'(s * 16'h1357));
        wr(adr(7, 7), 32'h0000_0C04);
        wr(adr(2, 7), 32'hDEAD_BEEF);
        for (int s = 0; s < 7; s++) rd_chk(adr(3, s), model_read(adr(3, s)), "R2");
        rd_chk(adr(3, 6), 32'hA500_0000 | 32'(6 * 16'h1357), "R2");
        rd_chk(adr(7, 7), 32'h0000_0C04, "R2");
        rd_chk(adr(2, 7), 32'h0, "R2");
        rd_chk(adr(3, 0) | 8'h3, model_read(adr(3, 0)), "R2");

        // R3: low mask bits read as zero
        wr(adr(5, 4), 32'hFFFF_FFFF);
        rd_chk(adr(5, 4), 32'hFFFF_0000, "R3");
        for (int s = 0; s < 7; s++) begin wr(adr(3, s), 32'h0); wr(adr(5, s), 32'h0); end

        // R5: hand-computed translation
        prog_win(0, 64'h0000_0012_3450_0001, 64'h0000_00AB_CD00_0000,
                 64'hFFFF_FFFF_FFF0_0000, {20'h0, 1'b1, 3'd2, 4'h0, ACT_IO});
        lookup(64'h0000_0012_345A_BCDE, 1, "R5");
        @(posedge clk); #1;
        check(rsp_addr, 64'h0000_00AB_CD0A_BCDE, "R5", "hand rsp_addr");
        check(64'(rsp_action), 64'h0000_0A04, "R5", "hand rsp_action");
        check(64'(rsp_win), 64'h0, "R5", "hand rsp_win");

        // R4: cleared enable bit
        wr(adr(0, 0), 32'h3450_0000);
        lookup(64'h0000_0012_345A_BCDE, 1, "R4");
        @(posedge clk); #1;
        check(64'(rsp_hit), 64'h0, "R4", "disabled window hit");
        wr(adr(0, 0), 32'h3450_0001);

        // R6: overlapping windows
        prog_win(1, 64'h0000_0012_0000_0001, 64'h0000_0300_0000_0000,
                 64'hFFFF_FFF0_0000_0000, {28'h0, ACT_MEM});
        lookup(64'h0000_0012_3451_0000, 1, "R6");
        @(posedge clk); #1;
        check(64'(rsp_win), 64'h0, "R6", "lowest window wins");
        for (int s = 0; s < 7; s++) wr(adr(0, s), 32'h0);
        lookup(64'h0000_0012_3451_0000, 1, "R4");
        @(posedge clk); #1;
        check(64'(rsp_win), 64'h1, "R4", "zeroed window skipped");
        check(rsp_addr, 64'h0000_0302_3451_0000, "R6", "next window addr");

        // R7 / R8: misses
        lookup(64'h0000_0099_0000_1234, 1, "R7");
        lookup(64'h0000_0099_0000_1234, 0, "R8");
        lookup(64'h0000_0001_0000_0000, 0, "R8");

        // R11: write lands with the lookup that it disables
        step(1, 64'h0000_0015_0000_0000, 1, 1, 1, adr(1, 0), 32'h0, "R11");
        lookup(64'h0000_0015_0000_0000, 1, "R11");
        @(posedge clk); #1;
        check(64'(rsp_hit), 64'h0, "R11", "later lookup after disable");
        wr(adr(1, 0), 32'h0000_0001);

        // R10: stall while windows are rewritten
        step(1, 64'h0000_0017_0000_0000, 1, 1, 0, 8'h0, 32'h0, "R10");
        for (int k = 0; k < 3; k++)
            step(1, 64'h0000_0099_0000_0000, 0, 0, 1, adr(1, 2 + k), 32'h5555_0000, "R10");
        step(0, 64'h0, 1, 1, 0, 8'h0, 32'h0, "");

        // program all windows with aligned masks
        for (int w = 0; w < 8; w++) begin
            int k;
            logic [63:0] mk;
            k  = 16 + int'($urandom % 32);
            mk = ~((64'd1 << k) - 64'd1);
            prog_win(w, ({$urandom, $urandom} & mk) | 64'd1, {$urandom, $urandom}, mk,
                     {$urandom} & 32'h0000_0FF0 | 32'(w % 2 ? ACT_MEM : ACT_MSG));
        end
        wr(adr(7, 7), 32'h0000_0104);

        // random traffic mixed with writes and stalls
        for (int n = 0; n < 3000; n++) begin
            logic [63:0] a;
            logic [31:0] wd;
            logic [7:0]  wa;
            int          w;
            w = int'($urandom % 8);
            if ($urandom % 4 == 0) a = {$urandom, $urandom};
            else a = (m_match[w] & m_mask[w]) | ({$urandom, $urandom} & ~m_mask[w]);
            wa = 8'($urandom);
            wd = $urandom;
            if (wa[4:2] == 3'd0) wd[0] = ($urandom % 4 != 0);
            step($urandom % 4 != 0, a, $urandom % 2 == 0, $urandom % 4 != 0,
                 $urandom % 6 == 0, wa, wd, "");
        end
        step(0, 64'h0, 1, 1, 0, 8'h0, 32'h0, "");
        step(0, 64'h0, 1, 1, 0, 8'h0, 32'h0, "");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule